// File: doc/BRIEF.md
# Transmit Rail Formatter and Zero-Substitution Encoder

This block sits between terminal equipment and a bipolar line driver. It takes the transmit data either as a pair of rails, one asking for positive marks and one for negative marks, or as a single binary stream. In the binary case a zero-substitution line encoder turns ones into alternating marks. It also replaces runs of zeros with a pattern that contains a deliberate bipolar violation. HDB3 is used at the E3 rate and B3ZS at the DS3 and STS-1 rates. The outputs are two registered pulse-request levels, one for each polarity. Each level is held for one line-bit period and feeds the pulse shaper.

All logic runs on a fast system clock `clk`. The line clock and the data inputs are brought into this domain through synchronizer stages. The active edge of the line clock is found from the synchronized copy. Control bits are loaded through a three-wire serial write port. The line clock paces the data, so there is no valid/ready handshake. Every bit period, the terminal equipment presents one bit per rail and the block always accepts it, because no back-pressure is possible on a line. Control inputs and outputs are plain levels.

Top module: `tx_rail_fmt`

## Requirements
- R1: After reset, `pulse_pos`, `pulse_neg` and `drv_level` are 0. The control word is cleared, which selects dual-rail input, normal clock polarity, no all-ones and transmit enabled.
- R2: Input sampling happens at the falling edge of `line_clk`, or at the rising edge when the clock-invert control bit is set. The pulse outputs change only on the third rising edge of `clk` after the sampling edge is applied, and they hold between samples.
- R3: With the single-rail bit and the all-ones bit clear, each sample copies `pos_in` to `pulse_pos` and `neg_in` to `pulse_neg`.
- R4: A serial write is 16 bits, MSB first. Each bit is taken on a rising edge of `sp_sck` while `sp_cs` is high. Bits 15:8 are the address and bits 7:0 are the data. On the 16th bit, address 0x01 loads data bits 4:0 into the control word. Any other address leaves the control word unchanged.
- R5: The control word bits are: bit 0 single-rail input, bit 1 drive level (shown on `drv_level`), bit 2 clock invert, bit 3 all-ones, bit 4 transmit off. Data bits 7:5 are ignored.
- R6: In single-rail mode, `neg_in` has no effect on the outputs.
- R7: In single-rail mode, encoded ones are output as marks of alternating polarity. The first mark after reset is positive. The two outputs are never both 1.
- R8: With `rate_e3` = 1 (HDB3), the data is delayed by 4 samples. The delay line starts filled with zeros. Each run of four zeros becomes B00V when an even number of marks has been sent since the last violation, and 000V otherwise. B takes the next alternating polarity. V repeats the polarity of the mark just before it.
- R9: With `rate_e3` = 0 (B3ZS), the delay is 3 samples. Each run of three zeros becomes B0V when the count of marks since the last violation is even, and 00V otherwise, with the same polarity rules as R8.
- R10: Successive violations alternate in polarity.
- R11: When the all-ones bit is set, the encoder receives a 1 on every sample, whatever `pos_in` and the single-rail bit are.
- R12: While transmit off is set, both pulse outputs are 0 from the next `clk` edge on. The encoder keeps advancing in the background.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the line clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_clk | input | 1 | Transmit line clock from the terminal equipment |
| pos_in | input | 1 | Positive rail, or the binary data in single-rail mode |
| neg_in | input | 1 | Negative rail (unused in single-rail mode) |
| rate_e3 | input | 1 | 1 selects HDB3 (E3), 0 selects B3ZS (DS3/STS-1) |
| sp_cs | input | 1 | Serial write frame enable, active high |
| sp_sck | input | 1 | Serial write clock |
| sp_sdi | input | 1 | Serial write data |
| pulse_pos | output | 1 | Registered positive pulse request |
| pulse_neg | output | 1 | Registered negative pulse request |
| drv_level | output | 1 | Drive-level control bit for the line driver |

## Verification
The hardest behaviour to reach is the choice between the two substitution patterns. That choice depends on the parity of marks since the last violation, so both patterns only show up when zero runs follow odd and even mark counts in many orders. The stimulus uses sparse random data with long zero runs, pure zero stretches and dense mixes in both coding rates. A behavioural queue model predicts every output level on every clock. A decoder watching the output stream checks that the violation polarity alternates.

// File: rtl/tx_line_pkg.sv
package tx_line_pkg;

  // Symbol held in the encoder delay line.
  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,
    SYM_MARK = 2'd1,
    SYM_BAL  = 2'd2,
    SYM_VIOL = 2'd3
  } sym_e;

  // Control word, MSB first: bit 4 down to bit 0.
  typedef struct packed {
    logic tx_off;
    logic all_ones;
    logic clk_inv;
    logic drv_lvl;
    logic bin_mode;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/sync_stages.sv
module sync_stages #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= '0;
    else        st[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[g] <= '0;
      else        st[g] <= st[g-1];
    end
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/ser_ctl_port.sv
module ser_ctl_port
  import tx_line_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int CTL_ADDR = 1,
  parameter int SYNC     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sck,
  input  logic sdi,
  output ctl_t ctl_q
);

  localparam int FRAME = ADDR_W + DATA_W;
  localparam int CNT_W = $clog2(FRAME + 1);

  logic cs_s, sck_s, sdi_s, sck_d, sck_rise;
  logic [FRAME-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic [FRAME-1:0] word;
  logic             last_bit;

  sync_stages #(.W(3), .STAGES(SYNC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs, sck, sdi}),
    .q     ({cs_s, sck_s, sdi_s})
  );

  assign sck_rise = sck_s & ~sck_d;
  assign word     = {sh_q[FRAME-2:0], sdi_s};
  assign last_bit = cs_s && sck_rise && (cnt_q == CNT_W'(FRAME - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sck_d <= sck_s;
      if (!cs_s) begin
        cnt_q <= '0;
      end else if (sck_rise && cnt_q != CNT_W'(FRAME)) begin
        sh_q  <= word;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (last_bit && word[FRAME-1:DATA_W] == ADDR_W'(CTL_ADDR)) begin
      ctl_q <= ctl_t'(word[CTL_W-1:0]);
    end
  end

endmodule

// File: rtl/line_strobe.sv
module line_strobe #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_clk,
  input  logic pos_in,
  input  logic neg_in,
  input  logic inv,
  output logic strobe,
  output logic pos_s,
  output logic neg_s
);

  logic lc_s, lc_d;

  sync_stages #(.W(3), .STAGES(SYNC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({line_clk, pos_in, neg_in}),
    .q     ({lc_s, pos_s, neg_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lc_d <= 1'b0;
    else        lc_d <= lc_s;
  end

  // Falling edge normally, rising edge when inverted.
  assign strobe = inv ? (lc_s & ~lc_d) : (lc_d & ~lc_s);

endmodule

// File: rtl/zs_encoder.sv
module zs_encoder
  import tx_line_pkg::*;
#(
  parameter int HDB3_RUN = 4,
  parameter int B3ZS_RUN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic bit_in,
  input  logic hdb3,
  output logic emit_p,
  output logic emit_n,
  output logic emit_v
);

  localparam int DEPTH = (HDB3_RUN > B3ZS_RUN) ? HDB3_RUN : B3ZS_RUN;

  sym_e buf_q [DEPTH];
  sym_e nxt   [DEPTH];
  sym_e out_sym;
  logic last_pos_q, odd_q;
  logic pol, odd_after, all_zero, is_pulse;
  int   run;

  always_comb begin
    run      = hdb3 ? HDB3_RUN : B3ZS_RUN;
    out_sym  = hdb3 ? buf_q[HDB3_RUN-1] : buf_q[B3ZS_RUN-1];
    is_pulse = (out_sym != SYM_ZERO);
    pol      = (out_sym == SYM_VIOL) ? last_pos_q : ~last_pos_q;
    unique case (out_sym)
      SYM_VIOL:          odd_after = 1'b0;
      SYM_MARK, SYM_BAL: odd_after = ~odd_q;
      default:           odd_after = odd_q;
    endcase

    nxt[0] = bit_in ? SYM_MARK : SYM_ZERO;
    for (int i = 1; i < DEPTH; i++) nxt[i] = buf_q[i-1];

    all_zero = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      if (i < run && nxt[i] != SYM_ZERO) all_zero = 1'b0;
    end

    if (all_zero) begin
      nxt[0] = SYM_VIOL;
      if (hdb3) nxt[HDB3_RUN-1] = odd_after ? SYM_ZERO : SYM_BAL;
      else      nxt[B3ZS_RUN-1] = odd_after ? SYM_ZERO : SYM_BAL;
    end
  end

  assign emit_p = is_pulse & pol;
  assign emit_n = is_pulse & ~pol;
  assign emit_v = (out_sym == SYM_VIOL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) buf_q[i] <= SYM_ZERO;
      last_pos_q <= 1'b0;
      odd_q      <= 1'b0;
    end else if (adv) begin
      for (int i = 0; i < DEPTH; i++) buf_q[i] <= nxt[i];
      if (is_pulse) last_pos_q <= pol;
      odd_q <= odd_after;
    end
  end

endmodule

// File: rtl/tx_rail_fmt.sv
module tx_rail_fmt
  import tx_line_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int CTL_ADDR    = 1,
  parameter int HDB3_RUN    = 4,
  parameter int B3ZS_RUN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_clk,
  input  logic pos_in,
  input  logic neg_in,
  input  logic rate_e3,
  input  logic sp_cs,
  input  logic sp_sck,
  input  logic sp_sdi,
  output logic pulse_pos,
  output logic pulse_neg,
  output logic drv_level
);

  ctl_t ctl;
  logic strobe, pos_s, neg_s;
  logic enc_path, enc_bit, adv;
  logic emit_p, emit_n, emit_v;

  ser_ctl_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_ADDR(CTL_ADDR), .SYNC(SYNC_STAGES)
  ) u_port (
    .clk   (clk),
    .rst_n (rst_n),
    .cs    (sp_cs),
    .sck   (sp_sck),
    .sdi   (sp_sdi),
    .ctl_q (ctl)
  );

  line_strobe #(.SYNC(SYNC_STAGES)) u_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_clk (line_clk),
    .pos_in   (pos_in),
    .neg_in   (neg_in),
    .inv      (ctl.clk_inv),
    .strobe   (strobe),
    .pos_s    (pos_s),
    .neg_s    (neg_s)
  );

  assign enc_path = ctl.bin_mode | ctl.all_ones;
  assign enc_bit  = ctl.all_ones | pos_s;
  assign adv      = strobe & enc_path;

  zs_encoder #(.HDB3_RUN(HDB3_RUN), .B3ZS_RUN(B3ZS_RUN)) u_enc (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (adv),
    .bit_in (enc_bit),
    .hdb3   (rate_e3),
    .emit_p (emit_p),
    .emit_n (emit_n),
    .emit_v (emit_v)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_pos <= 1'b0;
      pulse_neg <= 1'b0;
    end else if (ctl.tx_off) begin
      pulse_pos <= 1'b0;
      pulse_neg <= 1'b0;
    end else if (strobe) begin
      pulse_pos <= enc_path ? emit_p : pos_s;
      pulse_neg <= enc_path ? emit_n : neg_s;
    end
  end

  assign drv_level = ctl.drv_lvl;

endmodule

// File: rtl/tx_rail_fmt_chk.sv
module tx_rail_fmt_chk (
  input logic clk,
  input logic rst_n,
  input logic strobe,
  input logic enc_path,
  input logic tx_off,
  input logic pos_s,
  input logic neg_s,
  input logic emit_p,
  input logic emit_v,
  input logic pulse_pos,
  input logic pulse_neg
);

  logic have_v, last_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_v <= 1'b0;
      last_v <= 1'b0;
    end else if (strobe && enc_path && emit_v) begin
      have_v <= 1'b1;
      last_v <= emit_p;
    end
  end

  a_r12_off_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    tx_off |=> (!pulse_pos && !pulse_neg));

  a_r3_dual_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !enc_path && !tx_off) |=>
      (pulse_pos == $past(pos_s) && pulse_neg == $past(neg_s)));

  a_r7_one_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && enc_path && !tx_off) |=> !(pulse_pos && pulse_neg));

  a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !tx_off) |=> ($stable(pulse_pos) && $stable(pulse_neg)));

  a_r10_viol_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && enc_path && emit_v && have_v) |-> (emit_p != last_v));

endmodule

bind tx_rail_fmt tx_rail_fmt_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .strobe    (strobe),
  .enc_path  (enc_path),
  .tx_off    (ctl.tx_off),
  .pos_s     (pos_s),
  .neg_s     (neg_s),
  .emit_p    (emit_p),
  .emit_v    (emit_v),
  .pulse_pos (pulse_pos),
  .pulse_neg (pulse_neg)
);

// File: tb/tx_rail_fmt_test.sv
module tx_rail_fmt_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic line_clk = 1'b0, pos_in = 1'b0, neg_in = 1'b0, rate_e3 = 1'b1;
  logic sp_cs = 1'b0, sp_sck = 1'b0, sp_sdi = 1'b0;
  logic pulse_pos, pulse_neg, drv_level;

  tx_rail_fmt uut (
    .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .pos_in(pos_in),
    .neg_in(neg_in), .rate_e3(rate_e3), .sp_cs(sp_cs), .sp_sck(sp_sck),
    .sp_sdi(sp_sdi), .pulse_pos(pulse_pos), .pulse_neg(pulse_neg),
    .drv_level(drv_level)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0, n_bad = 0;
  // model configuration
  bit m_bin, m_inv, m_ones, m_off, m_drv;
  // encoder model: q[0] oldest symbol; 0 zero, 1 mark, 2 balance, 3 violation
  int q[$];
  bit m_last, m_odd;
  bit pend_p, pend_n, exp_p, exp_n, upd;
  int cnt = 0;
  bit chk_en = 0;
  string tag = "R1";
  bit obs_seen, obs_last, obs_have_v, obs_vpol;

  task automatic check(string req, logic ap, logic an, bit ep, bit en);
    n_vec++;
    if (ap !== ep || an !== en) begin
      n_bad++;
      $display("FAIL %s: got pos=%b neg=%b expected pos=%b neg=%b at %0t",
               req, ap, an, ep, en, $time);
    end
  endtask

  task automatic model_enc(input bit b, output bit op, output bit on);
    int w, sym;
    bit pol, allz;
    w = rate_e3 ? 4 : 3;
    q.push_back(b ? 1 : 0);
    sym = q.pop_front();
    op = 0; on = 0;
    if (sym != 0) begin
      pol = (sym == 3) ? m_last : !m_last;
      op = pol; on = !pol;
      m_last = pol;
      m_odd = (sym == 3) ? 1'b0 : !m_odd;
    end
    allz = 1;
    foreach (q[i]) if (q[i] != 0) allz = 0;
    if (allz) begin
      q[w-1] = 3;
      q[0] = m_odd ? 0 : 2;
    end
  endtask

  // every clock: retire scheduled expectation, then compare
  always @(posedge clk) begin
    upd = 0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin exp_p = pend_p; exp_n = pend_n; upd = 1; end
    end
    if (m_off) begin exp_p = 0; exp_n = 0; end
    #2;
    if (chk_en) begin
      check(tag, pulse_pos, pulse_neg, exp_p, exp_n);
      // R10: observed violations alternate in polarity
      if (upd && (m_bin || m_ones) && !m_off && (pulse_pos ^ pulse_neg)) begin
        if (obs_seen && pulse_pos == obs_last) begin
          if (obs_have_v) begin
            n_vec++;
            if (pulse_pos == obs_vpol) begin
              n_bad++;
              $display("FAIL R10: violation polarity %b repeats previous %b",
                       pulse_pos, obs_vpol);
            end
          end
          obs_vpol = pulse_pos; obs_have_v = 1;
        end
        obs_last = pulse_pos; obs_seen = 1;
      end
    end
  end

  task automatic do_reset(bit e3);
    chk_en = 0;
    @(negedge clk);
    rst_n = 0; rate_e3 = e3; line_clk = 0; pos_in = 0; neg_in = 0;
    m_bin = 0; m_inv = 0; m_ones = 0; m_off = 0; m_drv = 0;
    q.delete();
    for (int i = 0; i < (e3 ? 4 : 3); i++) q.push_back(0);
    m_last = 0; m_odd = 0; cnt = 0; exp_p = 0; exp_n = 0;
    obs_seen = 0; obs_have_v = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_en = 1;
  endtask

  task automatic sp_write(bit [7:0] addr, bit [7:0] data);
    bit [15:0] w;
    w = {addr, data};
    chk_en = 0;
    @(negedge clk);
    sp_cs = 1;
    for (int i = 15; i >= 0; i--) begin
      sp_sdi = w[i];
      repeat (2) @(negedge clk);
      sp_sck = 1;
      repeat (3) @(negedge clk);
      sp_sck = 0;
      repeat (2) @(negedge clk);
    end
    sp_cs = 0;
    if (addr == 8'h01) begin
      m_bin = data[0]; m_drv = data[1]; m_inv = data[2];
      m_ones = data[3]; m_off = data[4];
    end
    repeat (5) @(negedge clk);
    chk_en = 1;
  endtask

  task automatic send_bit(bit p, bit n);
    bit ep, en;
    @(negedge clk);
    line_clk = m_inv ? 1'b0 : 1'b1;
    pos_in = p; neg_in = n;
    repeat (HALF_BIT) @(posedge clk);
    @(negedge clk);
    line_clk = m_inv ? 1'b1 : 1'b0;
    if (m_bin || m_ones) model_enc(m_ones ? 1'b1 : p, ep, en);
    else begin ep = p; en = n; end
    pend_p = ep; pend_n = en; cnt = 3;
    repeat (HALF_BIT) @(posedge clk);
  endtask

  function automatic bit gen(int kind);
    case (kind)
      0: return 1'($urandom % 2);
      1: return ($urandom % 4) != 0;
      2: return ($urandom % 6) == 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic run(string t, int nbits, int kind);
    tag = t;
    for (int i = 0; i < nbits; i++) send_bit(gen(kind), 1'($urandom % 2));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset(1'b1);
    tag = "R1";
    check("R1", pulse_pos, pulse_neg, 1'b0, 1'b0);
    check("R1", drv_level, 1'b0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);

    // R3: dual-rail copy with both rails random
    run("R3", 30, 0);

    // R2: inverted clock edge
    sp_write(8'h01, 8'h04);
    run("R2", 30, 0);

    // R8 HDB3 with long zero runs, R6 neg ignored, R7 dense ones
    do_reset(1'b1);
    sp_write(8'h01, 8'h01);
    run("R8", 60, 2);
    tag = "R8";
    for (int i = 0; i < 14; i++) send_bit(1'b0, 1'b0);
    run("R6", 40, 0);
    run("R7", 40, 1);

    // R9 B3ZS
    do_reset(1'b0);
    sp_write(8'h01, 8'h01);
    run("R9", 60, 2);
    tag = "R9";
    for (int i = 0; i < 10; i++) send_bit(1'b0, 1'b1);
    run("R9", 40, 0);

    // R11 all-ones in dual-rail setting, data held low
    do_reset(1'b1);
    sp_write(8'h01, 8'h08);
    tag = "R11";
    for (int i = 0; i < 20; i++) send_bit(1'b0, 1'b1);

    // R12 transmit off then back on
    do_reset(1'b0);
    sp_write(8'h01, 8'h10);
    tag = "R12";
    for (int i = 0; i < 10; i++) send_bit(1'b1, 1'b0);
    sp_write(8'h01, 8'h00);
    for (int i = 0; i < 10; i++) send_bit(1'b1, 1'b1);

    // R4 other address ignored, R5 upper data bits ignored
    do_reset(1'b1);
    sp_write(8'h02, 8'h15);
    tag = "R4";
    for (int i = 0; i < 10; i++) send_bit(1'b1, 1'b0);
    check("R4", drv_level, 1'b0, 1'b0, 1'b0);
    sp_write(8'h01, 8'hE2);
    check("R5", drv_level, 1'b0, 1'b1, 1'b0);
    run("R5", 20, 0);

    chk_en = 0;
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule